// File: doc/BRIEF.md
# Access Permission Check and Fault Status Unit

This block judges one memory access against the 3-bit permission field of the page entry that maps it. The access has a kind (read, write or instruction fetch) and a privilege (user or supervisor). The block returns a fault code and the read, write and execute rights that may be cached for the page. Write rights are held back until the page entry already carries its modified mark. A no-fault mode, when enabled, lets user accesses go through even if they would fault.

Every fault that is reported is logged in two registers. A status word records the access index, the fault code, a valid flag and an overflow flag. The overflow flag marks a fault that arrived while an earlier, unread fault was still held. An address register keeps the page-aligned address of the fault. Software reads either register through a small port, and reading the status word empties it. Walking the page tables and forming the physical address are done elsewhere.

Top module: `perm_fault_unit`

## Requirements
- R1: The access index is `write<<2 | fetch<<1 | supervisor`. A logged fault puts the index in status bits [7:5], the fault code in bits [3:0] and a 1 in bit 1. For example, a user write that faults with code 8 logs 0x8A.
- R2: The fault code is 8 (protection) when the access needs a right that its permission value does not allow. A read with neither write nor fetch needs R, a write needs W, and a fetch needs X. The allowed sets are 0:R, 1:RW, 2:RX, 3:RWX and 4:X for both privileges. Value 5 allows R for a user and RW for a supervisor. Value 6 allows RX and value 7 allows RWX for a supervisor only. Otherwise the code is 0.
- R3: A user access to a page with permission value 6 or 7 yields code 12 (privilege) for every access kind.
- R4: The granted rights are the allowed set of R2, with none for a user at value 6 or 7. All rights are zero whenever a fault is reported.
- R5: The write right is granted only when the page's modified input is 1.
- R6: With no-fault mode on, a user access that would fault raises no fault flag, logs nothing and still receives its granted rights. Supervisor accesses are not affected by this mode.
- R7: When a fault is logged and the status word is nonzero and is not being read in that cycle, the new word is 1 ORed with the fields of R1. Bit 0 marks the overflow.
- R8: A logged fault loads the address register with the access address with its low page-offset bits cleared. Reading this register does not change it or the status word.
- R9: Reading the status word (select 0) returns its value in the same cycle and leaves it zero after the clock edge.
- R10: If a status read and a logged fault fall in the same cycle, the read returns the old word. The register then holds the new fault with no overflow bit.
- R11: After reset both registers read zero.
- R12: With the request input low, no fault is flagged and neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_perm | input | 3 | Permission field of the page entry |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is from supervisor mode |
| acc_modified | input | 1 | Page entry already marked modified |
| acc_addr | input | AW | Virtual address of the access |
| nofault_en | input | 1 | No-fault mode for user accesses |
| fault_code | output | 4 | 0, 8 (protection) or 12 (privilege), before suppression |
| fault_flag | output | 1 | A fault is reported and logged this cycle |
| grant_r | output | 1 | Read right granted |
| grant_w | output | 1 | Write right granted |
| grant_x | output | 1 | Execute right granted |
| sw_rd | input | 1 | Software read strobe |
| sw_sel | input | 1 | 0 selects the status word, 1 the fault address |
| sw_rdata | output | AW | Selected register, zero-extended |

## Verification
A logged fault and a software read of the status word can happen in the same cycle. In that case the clear and the capture compete for one register, and the overflow rule depends on which one wins. The bench first creates an unread fault. It then presents a second faulting access together with a status read. It expects the read data to show the first word, and a later read to show the second fault without its overflow bit. A behavioural model checks the same overlap again during the permission sweeps, where reads are spread among faulting accesses.

// File: rtl/pfu_pkg.sv
// Package pfu_pkg
// Shared constants and types for the permission/fault unit.
// Assumes the status word is 8 bits wide, with the field layout fixed by the requirements.
package pfu_pkg;
    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } rights_t;

    localparam logic [3:0] CODE_NONE = 4'd0;
    localparam logic [3:0] CODE_PROT = 4'd8;
    localparam logic [3:0] CODE_PRIV = 4'd12;

    localparam int STAT_W    = 8;
    localparam int IDX_LSB   = 5;
    localparam int VALID_BIT = 1;
    localparam int OVF_BIT   = 0;
endpackage

// File: rtl/pfu_perm_decode.sv
// Module pfu_perm_decode
// Purely combinational. Maps a permission value, an access kind and a privilege
// to a raw fault code and to the rights that may be granted.
// Assumes write and fetch together demand both rights.
module pfu_perm_decode
    import pfu_pkg::*;
(
    input  logic [2:0] perm,
    input  logic       is_write,
    input  logic       is_fetch,
    input  logic       is_super,
    input  logic       modified,
    output logic [3:0] code,
    output rights_t    granted
);
    rights_t allow;
    logic    priv_viol;
    logic    is_read;
    logic    missing;

    // Select the rights the permission value allows for this privilege.
    always_comb begin
        allow = '0;
        case (perm)
            3'd0: allow = '{r: 1'b1, w: 1'b0, x: 1'b0};
            3'd1: allow = '{r: 1'b1, w: 1'b1, x: 1'b0};
            3'd2: allow = '{r: 1'b1, w: 1'b0, x: 1'b1};
            3'd3: allow = '{r: 1'b1, w: 1'b1, x: 1'b1};
            3'd4: allow = '{r: 1'b0, w: 1'b0, x: 1'b1};
            3'd5: allow = '{r: 1'b1, w: is_super, x: 1'b0};
            3'd6: allow = '{r: is_super, w: 1'b0, x: is_super};
            default: allow = '{r: is_super, w: is_super, x: is_super};
        endcase
    end

    // Check each demanded right against the allowed set.
    always_comb begin
        is_read   = !is_write && !is_fetch;
        priv_viol = !is_super && (perm[2:1] == 2'b11);
        missing   = (is_write && !allow.w) || (is_fetch && !allow.x) || (is_read && !allow.r);
        if (priv_viol)    code = CODE_PRIV;
        else if (missing) code = CODE_PROT;
        else              code = CODE_NONE;
    end

    // Withhold the write right until the page is marked modified.
    always_comb begin
        granted   = allow;
        granted.w = allow.w && modified;
    end
endmodule

// File: rtl/pfu_fault_regs.sv
// Module pfu_fault_regs
// Holds the fault status word and the fault address register.
// Assumes fault_ev is asserted for at most one access per cycle.
// A clear that coincides with a fault consumes the old word, so no overflow is marked.
module pfu_fault_regs
    import pfu_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_ev,
    input  logic [2:0]        idx,
    input  logic [3:0]        code,
    input  logic [AW-1:0]     addr,
    input  logic              clr_stat,
    output logic [STAT_W-1:0] stat_q,
    output logic [AW-1:0]     addr_q
);
    localparam logic [AW-1:0] PG_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

    logic [STAT_W-1:0] fields;
    logic              ovf;

    // Build the fields of the new status word.
    always_comb begin
        fields            = '0;
        fields[IDX_LSB+:3] = idx;
        fields[3:0]       = code;
        fields[VALID_BIT] = 1'b1;
        ovf               = (stat_q != '0) && !clr_stat;
    end

    // Update the status word on a fault or a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= '0;
        else if (fault_ev) stat_q <= fields | STAT_W'(ovf);
        else if (clr_stat) stat_q <= '0;
    end

    // Capture the page-aligned address of each logged fault.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr_q <= '0;
        else if (fault_ev) addr_q <= addr & PG_MASK;
    end
endmodule

// File: rtl/pfu_sw_port.sv
// Module pfu_sw_port
// Software read port: selects a register and raises the clear for status reads.
// Assumes AW is at least STAT_W.
module pfu_sw_port
    import pfu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              sw_rd,
    input  logic              sw_sel,
    input  logic [STAT_W-1:0] stat_q,
    input  logic [AW-1:0]     addr_q,
    output logic [AW-1:0]     sw_rdata,
    output logic              clr_stat
);
    // Multiplex the selected register and decode the read-clear.
    always_comb begin
        sw_rdata = sw_sel ? addr_q : AW'(stat_q);
        clr_stat = sw_rd && !sw_sel;
    end
endmodule

// File: rtl/perm_fault_unit.sv
// Module perm_fault_unit
// Top level. Judges an access against the page permission field, applies the
// no-fault override for user accesses, and logs reported faults for software.
// Assumes the rights outputs are used only when acc_valid is high.
module perm_fault_unit
    import pfu_pkg::*;
#(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_valid,
    input  logic [2:0]    acc_perm,
    input  logic          acc_write,
    input  logic          acc_fetch,
    input  logic          acc_super,
    input  logic          acc_modified,
    input  logic [AW-1:0] acc_addr,
    input  logic          nofault_en,
    output logic [3:0]    fault_code,
    output logic          fault_flag,
    output logic          grant_r,
    output logic          grant_w,
    output logic          grant_x,
    input  logic          sw_rd,
    input  logic          sw_sel,
    output logic [AW-1:0] sw_rdata
);
    rights_t           granted;
    logic [3:0]        raw_code;
    logic [2:0]        acc_idx;
    logic              suppress;
    logic              blocked;
    logic              clr_stat;
    logic [STAT_W-1:0] stat_q;
    logic [AW-1:0]     addr_q;

    pfu_perm_decode u_dec (
        .perm     (acc_perm),
        .is_write (acc_write),
        .is_fetch (acc_fetch),
        .is_super (acc_super),
        .modified (acc_modified),
        .code     (raw_code),
        .granted  (granted)
    );

    // Form the access index and decide whether the fault is reported.
    always_comb begin
        acc_idx    = {acc_write, acc_fetch, acc_super};
        suppress   = nofault_en && !acc_super;
        blocked    = (raw_code != CODE_NONE) && !suppress;
        fault_flag = acc_valid && blocked;
        fault_code = raw_code;
        grant_r    = granted.r && !blocked;
        grant_w    = granted.w && !blocked;
        grant_x    = granted.x && !blocked;
    end

    pfu_fault_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_ev (fault_flag),
        .idx      (acc_idx),
        .code     (raw_code),
        .addr     (acc_addr),
        .clr_stat (clr_stat),
        .stat_q   (stat_q),
        .addr_q   (addr_q)
    );

    pfu_sw_port #(.AW(AW)) u_sw (
        .sw_rd    (sw_rd),
        .sw_sel   (sw_sel),
        .stat_q   (stat_q),
        .addr_q   (addr_q),
        .sw_rdata (sw_rdata),
        .clr_stat (clr_stat)
    );
endmodule

// File: rtl/pfu_checker.sv
// Module pfu_checker
// Assertions on the permission/fault unit, attached by bind.
module pfu_checker #(
    parameter int AW        = 32,
    parameter int PAGE_BITS = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fault_flag,
    input logic          acc_super,
    input logic [2:0]    acc_perm,
    input logic [3:0]    fault_code,
    input logic          acc_modified,
    input logic          grant_r,
    input logic          grant_w,
    input logic          grant_x,
    input logic          clr_stat,
    input logic [7:0]    stat_q,
    input logic [AW-1:0] acc_addr,
    input logic [AW-1:0] addr_q
);
    localparam logic [AW-1:0] PG_MASK = ~((AW'(1) << PAGE_BITS) - AW'(1));

    AST_FAULT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> stat_q[1]); // R1
    AST_PRIV_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_super && acc_perm[2:1] == 2'b11) |-> fault_code == 4'd12); // R3
    AST_NO_RIGHTS_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> !(grant_r || grant_w || grant_x)); // R4
    AST_WRITE_NEEDS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        grant_w |-> acc_modified); // R5
    AST_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && stat_q != 8'd0 && !clr_stat) |=> stat_q[0]); // R7
    AST_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |=> addr_q == ($past(acc_addr) & PG_MASK)); // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && !fault_flag) |=> stat_q == 8'd0); // R9
    AST_NO_OVERFLOW_ON_RACE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stat && fault_flag) |=> !stat_q[0]); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_flag && !clr_stat) |=> ($stable(stat_q) && $stable(addr_q))); // R12
endmodule

bind perm_fault_unit pfu_checker #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_pfu_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_flag   (fault_flag),
    .acc_super    (acc_super),
    .acc_perm     (acc_perm),
    .fault_code   (fault_code),
    .acc_modified (acc_modified),
    .grant_r      (grant_r),
    .grant_w      (grant_w),
    .grant_x      (grant_x),
    .clr_stat     (clr_stat),
    .stat_q       (stat_q),
    .acc_addr     (acc_addr),
    .addr_q       (addr_q)
);

// File: tb/tb_perm_fault_unit.sv
module tb_perm_fault_unit;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [2:0]    acc_perm = '0;
    logic          acc_write = 1'b0;
    logic          acc_fetch = 1'b0;
    logic          acc_super = 1'b0;
    logic          acc_modified = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic          nofault_en = 1'b0;
    logic [3:0]    fault_code;
    logic          fault_flag;
    logic          grant_r, grant_w, grant_x;
    logic          sw_rd = 1'b0;
    logic          sw_sel = 1'b0;
    logic [AW-1:0] sw_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int unsigned ref_stat = 0;
    int unsigned ref_addr = 0;

    // fault code table, row = access index, column = permission value
    int code_tab [0:63] = '{
        0, 0, 0, 0, 8, 0, 12, 12,
        0, 0, 0, 0, 8, 0, 0, 0,
        8, 8, 0, 0, 0, 8, 12, 12,
        8, 8, 0, 0, 0, 8, 0, 0,
        8, 0, 8, 0, 8, 8, 12, 12,
        8, 0, 8, 0, 8, 0, 8, 0,
        8, 8, 8, 0, 8, 8, 12, 12,
        8, 8, 8, 0, 8, 8, 8, 0
    };
    // rights as r<<2|w<<1|x, index = super*8 + perm
    int rts_tab [0:15] = '{4, 6, 5, 7, 1, 4, 0, 0,
                           4, 6, 5, 7, 1, 6, 5, 7};

    perm_fault_unit #(.AW(AW), .PAGE_BITS(12)) dut (.*);

    always #5 clk = ~clk;

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply one vector at a negedge, compare, then advance the model across the edge.
    task automatic step(bit v, int p, int idx, bit md, bit nf, int unsigned a,
                        bit rd, bit sel, string rtag);
        int raw, rts, exp_r;
        bit supp, blk, flg, clr;
        acc_valid = v; acc_perm = 3'(p);
        acc_write = idx[2]; acc_fetch = idx[1]; acc_super = idx[0];
        acc_modified = md; nofault_en = nf; acc_addr = a;
        sw_rd = rd; sw_sel = sel;
        #1;
        raw  = code_tab[idx*8 + p];
        supp = nf && !idx[0];
        blk  = (raw != 0) && !supp;
        flg  = v && blk;
        rts  = rts_tab[idx[0]*8 + p];
        if (!md) rts = rts & 5;
        exp_r = blk ? 0 : rts;
        chk((!idx[0] && p >= 6) ? "R3" : "R2", fault_code, raw);
        chk(!v ? "R12" : (supp && raw != 0) ? "R6" : "R2", fault_flag, flg);
        chk((supp && raw != 0) ? "R6" : "R4", {grant_r, grant_w, grant_x}, exp_r);
        chk("R5", grant_w, exp_r[1]);
        chk(rtag, sw_rdata, sel ? ref_addr : ref_stat);
        clr = rd && !sel;
        @(posedge clk);
        if (flg) begin
            ref_stat = ((ref_stat != 0 && !clr) ? 1 : 0) | (idx << 5) | raw | 2;
            ref_addr = a & 32'hFFFF_F000;
        end else if (clr) begin
            ref_stat = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state of both registers
        step(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R11");
        // R1: user write to read-only page, then read the status word
        step(1, 0, 4, 0, 0, 32'h1234_5678, 0, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R1");
        chk("R1", ref_stat, 0);
        step(0, 0, 0, 0, 0, 0, 1, 1, "R8");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R9");
        // R7: two faults with no read between them
        step(1, 0, 4, 0, 0, 32'h0000_1FFF, 0, 0, "R7");
        step(1, 6, 2, 0, 0, 32'hABCD_E123, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R7");
        // R10: status read in the same cycle as a new fault
        step(1, 0, 4, 0, 0, 32'h0000_3000, 0, 0, "R10");
        step(1, 4, 0, 1, 0, 32'h0000_4444, 1, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R10");
        // R2 R3 R4 R5: full sweep, reads interleaved
        for (int nf = 0; nf < 2; nf++) begin
            for (int p = 0; p < 8; p++) begin
                for (int idx = 0; idx < 8; idx++) begin
                    for (int md = 0; md < 2; md++) begin
                        int k = p*16 + idx*2 + md;
                        step(1, p, idx, md[0], nf[0], k * 32'h0001_0357,
                             (k % 5) == 0, (k % 10) == 5, ((k % 10) == 5) ? "R8" : "R9");
                    end
                end
            end
        end
        // R12: requests held low never log
        for (int p = 0; p < 8; p++)
            step(0, p, 4, 0, 0, 32'hFFFF_FFFF, 0, p[0], "R12");
        step(0, 0, 0, 0, 0, 0, 1, 0, "R12");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule